// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block produces the chip-select lines of an SPI master. A small select field names the target device, and the block drives that device's line while the other lines rest at their idle level. In automatic operation the shift engine reports when a burst is running through `burstActive`, and a one-cycle `sckTick` pulse marks each serial-clock period. The selected line is asserted when a burst starts. It is released one serial-clock period after the burst's last bit, at the first tick seen once `burstActive` has dropped.

In manual operation the controller does not follow the burst. Software supplies a raw level that is placed directly on the selected line. One polarity control sets the active level of an automatic assertion, and it also sets the level at which every unselected line rests. Every output comes from a flip-flop, so a change of select field cannot cause a combinational glitch on any line.

Top module: `spi_cs_select`

## Requirements
- R1: During reset, and on the first clock after reset is released, every line of `csOut` is 1 (deasserted, high).
- R2: A line that is neither driven by a burst nor selected in manual mode sits at the value of `activeLow`: high when it is 1 and low when it is 0.
- R3: In automatic mode (`manualEn`=0), a clock edge that samples `burstActive`=1 drives the burst's line to the inverse of `activeLow` from that edge on.
- R4: Select value n (0 to 3) on `csSel` targets `csOut[n]`. The field's bit 0 is the least significant bit of the index.
- R5: The select value is captured at the edge that starts a burst from idle. Changing `csSel` during the burst or its tail has no effect on which line is asserted.
- R6: After `burstActive` returns to 0, the line stays asserted until the first edge that samples `sckTick`=1 and is then released at that edge. Ticks seen while `burstActive`=1 do not release it.
- R7: If `burstActive` returns to 1 during the tail, the line stays asserted with no gap and keeps the captured select value.
- R8: With `manualEn`=1, one clock after the inputs are sampled, `csOut[csSel]` equals `manualLevel` exactly as given and every other line sits at its idle level.
- R9: At no time does more than one line differ from the idle level set by the previous cycle's `activeLow`.
- R10: A change of `activeLow` takes effect at the next clock edge, both for idle lines and for the active level of an asserted line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csSel | input | 2 | Index of the target device |
| manualEn | input | 1 | 1 hands the selected line's level to `manualLevel` |
| manualLevel | input | 1 | Raw level for the selected line in manual mode |
| activeLow | input | 1 | 1: lines assert low and idle high; 0: assert high and idle low |
| burstActive | input | 1 | High while the shift engine is running a burst |
| sckTick | input | 1 | One-cycle pulse once per serial-clock period |
| csOut | output | 4 | Registered chip-select lines |

## Verification
The automatic path is exercised with bursts on every select value, with `csSel` moved in the middle of a burst, with ticks arriving both inside a burst and after it, and with a burst restarted during the tail. Together these separate a correct capture-and-hold of the select from a design that follows the live field, and separate a correct tail release from one that releases early or late. Manual mode is swept over all select values and both levels while a burst is also running, which shows that the raw level, not the burst, reaches the line. Flipping the polarity while lines are idle and while one is asserted shows that the idle level and the active level both follow the one control.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  // Burst tracking state of the control path
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_BURST = 2'd1,
    CS_TAIL  = 2'd2
  } csState_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic captureSel;  // a burst starts from idle this cycle: take the select field
    logic lineOn;      // the burst line must be asserted after this edge
  } csStrobe_t;

endpackage

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      burstActive,
  input  logic      sckTick,
  output csStrobe_t strobe
);

  csState_e state;
  csState_e stateNext;

  // Next-state logic: a running burst always wins over a tail release
  always_comb begin
    stateNext = state;
    unique case (state)
      CS_IDLE:  if (burstActive) stateNext = CS_BURST;
      CS_BURST: if (!burstActive) stateNext = CS_TAIL;
      CS_TAIL: begin
        if (burstActive)  stateNext = CS_BURST;
        else if (sckTick) stateNext = CS_IDLE;
      end
      default:  stateNext = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CS_IDLE;
    else        state <= stateNext;
  end

  // Strobes are taken from the next state so the registered line moves
  // on the same edge that samples the burst input
  always_comb begin
    strobe.captureSel = (state == CS_IDLE) && burstActive;
    strobe.lineOn     = (stateNext != CS_IDLE);
  end

endmodule

// File: rtl/spi_cs_datapath.sv
module spi_cs_datapath
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  csStrobe_t         strobe,
  input  logic [SEL_W-1:0]  csSel,
  input  logic              manualEn,
  input  logic              manualLevel,
  input  logic              activeLow,
  output logic [NUM_CS-1:0] csOut
);

  logic [SEL_W-1:0]  selHeld;
  logic [SEL_W-1:0]  burstSel;
  logic [SEL_W-1:0]  driveSel;
  logic [NUM_CS-1:0] lineNext;

  // Select captured only at burst start; held through burst and tail
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 selHeld <= '0;
    else if (strobe.captureSel) selHeld <= csSel;
  end

  assign burstSel = strobe.captureSel ? csSel : selHeld;
  assign driveSel = manualEn ? csSel : burstSel;

  // One level decision per line
  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    logic lineHit;
    assign lineHit = (driveSel == SEL_W'(g));
    always_comb begin
      if (manualEn)
        lineNext[g] = lineHit ? manualLevel : activeLow;
      else
        lineNext[g] = (strobe.lineOn && lineHit) ? ~activeLow : activeLow;
    end
  end

  // Registered outputs, deasserted high out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csOut <= '1;
    else        csOut <= lineNext;
  end

endmodule

// File: rtl/spi_cs_select.sv
module spi_cs_select
  import spi_cs_pkg::*;
#(
  parameter  int NUM_CS = 4,
  localparam int SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  csSel,
  input  logic              manualEn,
  input  logic              manualLevel,
  input  logic              activeLow,
  input  logic              burstActive,
  input  logic              sckTick,
  output logic [NUM_CS-1:0] csOut
);

  csStrobe_t strobe;

  spi_cs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .burstActive (burstActive),
    .sckTick     (sckTick),
    .strobe      (strobe)
  );

  spi_cs_datapath #(
    .NUM_CS (NUM_CS),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .csSel       (csSel),
    .manualEn    (manualEn),
    .manualLevel (manualLevel),
    .activeLow   (activeLow),
    .csOut       (csOut)
  );

endmodule

// File: rtl/spi_cs_checker.sv
module spi_cs_checker
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  csSel,
  input logic              manualEn,
  input logic              manualLevel,
  input logic              activeLow,
  input logic              burstActive,
  input logic              sckTick,
  input csStrobe_t         strobe,
  input logic [NUM_CS-1:0] csOut
);

  // R1: lines still high at the first edge after reset release
  p_reset_high_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (csOut == {NUM_CS{1'b1}}));

  // R2: no burst line and automatic mode: every line idles at the polarity level
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!manualEn && !strobe.lineOn) |=> (csOut == {NUM_CS{$past(activeLow)}}));

  // R3: a sampled burst asserts some line on the next cycle
  p_burst_assert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!manualEn && burstActive) |=> (csOut != {NUM_CS{$past(activeLow)}}));

  // R6: release only on a tick with the burst gone
  p_tail_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe.lineOn) |-> (sckTick && !burstActive));

  // R8: manual level reaches the selected line unchanged
  p_manual_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    manualEn |=> (csOut[$past(csSel)] == $past(manualLevel)));

  // R9: at most one line away from idle
  p_one_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(csOut ^ {NUM_CS{$past(activeLow)}}) <= 1));

endmodule

bind spi_cs_select spi_cs_checker #(
  .NUM_CS (NUM_CS),
  .SEL_W  (SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csSel       (csSel),
  .manualEn    (manualEn),
  .manualLevel (manualLevel),
  .activeLow   (activeLow),
  .burstActive (burstActive),
  .sckTick     (sckTick),
  .strobe      (strobe),
  .csOut       (csOut)
);

// File: tb/spi_cs_select_bench.sv
`timescale 1ns/1ps
module spi_cs_select_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] csSel = 2'd0;
  logic       manualEn = 1'b0;
  logic       manualLevel = 1'b0;
  logic       activeLow = 1'b1;
  logic       burstActive = 1'b0;
  logic       sckTick = 1'b0;
  logic [3:0] csOut;

  int    checks = 0;
  int    failures = 0;
  int    cycleCount = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  // Reference model state
  int       mState = 0;   // 0 idle, 1 burst, 2 tail
  int       mSel = 0;
  logic [3:0] expOut = 4'hF;

  // Tick generator controls (driven from tasks)
  bit tickEn = 1'b0;
  int tickCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  spi_cs_select u_spi_cs_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .csSel       (csSel),
    .manualEn    (manualEn),
    .manualLevel (manualLevel),
    .activeLow   (activeLow),
    .burstActive (burstActive),
    .sckTick     (sckTick),
    .csOut       (csOut)
  );

  // Behavioural model, evaluated at each rising edge on stable inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mState = 0;
      mSel   = 0;
      expOut = 4'hF;
    end else begin
      int nState;
      nState = mState;
      if (burstActive) begin
        if (mState == 0) mSel = int'(csSel);
        nState = 1;
      end else if (mState == 1) begin
        nState = 2;
      end else if (mState == 2 && sckTick) begin
        nState = 0;
      end
      mState = nState;
      for (int i = 0; i < 4; i++) begin
        if (manualEn)
          expOut[i] = (i == int'(csSel)) ? manualLevel : activeLow;
        else
          expOut[i] = (mState != 0 && i == mSel) ? ~activeLow : activeLow;
      end
    end
  end

  // Compare on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (csOut !== expOut) begin
        failures++;
        $display("FAIL %s: csOut actual=%b expected=%b at cycle %0d",
                 curReq, csOut, expOut, cycleCount);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 20000 && !finished) begin
      failures++;
      finished = 1'b1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Advance one cycle; inputs change only on falling edges
  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      sckTick = tickEn && (tickCnt % 4 == 3);
      tickCnt++;
    end
  endtask

  task automatic explicitCheck(string req, logic [3:0] want);
    checks++;
    if (csOut !== want) begin
      failures++;
      $display("FAIL %s: csOut actual=%b expected=%b", req, csOut, want);
    end
  endtask

  // Burst of given length on a device, then wait out the tail
  task automatic burst(int dev, int len);
    csSel = 2'(dev);
    burstActive = 1'b1;
    step(len);
    burstActive = 1'b0;
    step(8);
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    step(2);
    explicitCheck("R1", 4'hF);
    rst_n = 1'b1;
    step(1);
    explicitCheck("R1", 4'hF);

    // R2 and R10: idle level follows polarity
    curReq = "R2";
    step(3);
    explicitCheck("R2", 4'hF);
    curReq = "R10";
    activeLow = 1'b0;
    step(2);
    explicitCheck("R10", 4'h0);
    activeLow = 1'b1;
    step(2);

    // R3, R4, R6: bursts on each device, ticks running
    tickEn = 1'b1;
    curReq = "R3";
    burst(0, 3);
    curReq = "R4";
    for (int d = 0; d < 4; d++) burst(d, 5);

    // R6: ticks during a long burst must not release
    curReq = "R6";
    csSel = 2'd2;
    burstActive = 1'b1;
    step(10);
    explicitCheck("R6", 4'b1011);
    burstActive = 1'b0;
    step(8);

    // R5: select change mid-burst and mid-tail ignored
    curReq = "R5";
    csSel = 2'd1;
    burstActive = 1'b1;
    step(2);
    csSel = 2'd3;
    step(3);
    explicitCheck("R5", 4'b1101);
    burstActive = 1'b0;
    csSel = 2'd0;
    step(1);
    explicitCheck("R5", 4'b1101);
    step(8);

    // R7: restart inside the tail, ticks held off so the tail lasts
    curReq = "R7";
    tickEn = 1'b0;
    sckTick = 1'b0;
    csSel = 2'd3;
    burstActive = 1'b1;
    step(3);
    burstActive = 1'b0;
    step(2);
    csSel = 2'd0;
    burstActive = 1'b1;
    step(3);
    explicitCheck("R7", 4'b0111);
    burstActive = 1'b0;
    step(3);
    sckTick = 1'b1;      // single tick releases the tail (R6)
    step(1);
    sckTick = 1'b0;
    step(2);
    explicitCheck("R6", 4'hF);

    // R8: manual sweep, with a burst also running
    curReq = "R8";
    manualEn = 1'b1;
    for (int d = 0; d < 4; d++) begin
      csSel = 2'(d);
      manualLevel = 1'b0;
      step(2);
      manualLevel = 1'b1;
      step(2);
    end
    burstActive = 1'b1;
    csSel = 2'd2;
    manualLevel = 1'b1;
    step(3);
    explicitCheck("R8", 4'hF);
    burstActive = 1'b0;
    tickEn = 1'b1;
    activeLow = 1'b0;
    manualLevel = 1'b1;
    step(3);
    explicitCheck("R8", 4'b0100);
    manualEn = 1'b0;
    step(8);

    // R10: active-high bursts, polarity flipped mid-burst
    curReq = "R10";
    burst(1, 4);
    csSel = 2'd3;
    burstActive = 1'b1;
    step(3);
    explicitCheck("R10", 4'b1000);
    activeLow = 1'b1;
    step(2);
    explicitCheck("R10", 4'b0111);
    burstActive = 1'b0;
    step(8);

    // R9 covered by the per-cycle comparison throughout
    curReq = "R9";
    step(4);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule